// File: doc/BRIEF.md
# Sign-Magnitude Ordering Comparator

This block compares two signed operands held in sign-magnitude form and reports whether the first is greater than, less than or equal to the second. Each operand is `N` bits wide. The top bit is the sign and the lower `N-1` bits are an unsigned magnitude. The block is purely combinational, so its flags follow its inputs with no clock and no latency.

Inside, each operand is rewritten as an unsigned key whose unsigned order matches the signed order of the original values. Both zero patterns are folded onto one key, so positive zero and negative zero compare equal. A plain unsigned comparator then ranks the two keys.

A mode input bypasses the rewrite and ranks the raw bit patterns as unsigned numbers. This lets the two orderings be set side by side, for example in a test or a demonstration.

Top module: `sm_order_cmp`

## Requirements
- R1: Bit `N-1` of each operand is its sign (0 for non-negative, 1 for negative), and bits `N-2:0` are its magnitude as an unsigned integer. In signed mode (`raw_mode`=0) the flags order the values decoded this way.
- R2: In signed mode, when the signs differ and neither magnitude is zero, the operand whose sign bit is 0 is reported greater.
- R3: In signed mode, when both operands are positive, the one with the larger magnitude is reported greater.
- R4: In signed mode, when both operands are negative, the one with the smaller magnitude is reported greater.
- R5: In signed mode, any two zero patterns compare equal. The zero patterns are all-zeros and sign 1 with a zero magnitude.
- R6: In signed mode, either zero pattern ranks above every negative non-zero value and below every positive non-zero value.
- R7: For every input pair and both modes, exactly one of `gt`, `lt`, `eq` is 1.
- R8: With `raw_mode`=1, the flags rank `op_a` and `op_b` as plain unsigned `N`-bit integers. For example, at N=5 the pattern 10001 ranks above 01111.
- R9: `eq` is 1 in signed mode exactly when the decoded values are equal, and in raw mode exactly when the two patterns are identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First operand, sign-magnitude |
| op_b | input | N | Second operand, sign-magnitude |
| raw_mode | input | 1 | 1 selects unsigned ranking of the raw patterns |
| gt | output | 1 | op_a ranks above op_b |
| lt | output | 1 | op_a ranks below op_b |
| eq | output | 1 | op_a and op_b rank equal |

## Verification
The bench runs every operand pair at N=5 in both modes and compares the flags with an ordering computed from the decoded integers.

The negative zero pattern is the sharpest corner case. Without the canonical zero key, negative zero would rank just above -1 but below positive zero, so `lt` would rise against positive zero. Pairs of two negatives would show up a key transform that skips the magnitude inversion, because the larger magnitude would then win. Pairs that straddle the sign boundary would show up a design that leaks raw unsigned ordering into signed mode, or that ignores `raw_mode`.

// File: rtl/sm_cmp_pkg.sv
package sm_cmp_pkg;

    typedef enum logic {
        CMP_SIGNED = 1'b0,
        CMP_RAW    = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } order_flags_t;

    function automatic order_flags_t flags_from_run(input logic above, input logic below);
        order_flags_t f;
        f.gt = above;
        f.lt = below;
        f.eq = ~(above | below);
        return f;
    endfunction

endpackage

// File: rtl/sm_key_map.sv
module sm_key_map #(
    parameter int N = 8
) (
    input  logic [N-1:0] operand,
    output logic [N-1:0] key
);
    localparam int MAG_W = N - 1;

    logic             sign_bit;
    logic [MAG_W-1:0] mag;
    logic             mag_zero;

    assign sign_bit = operand[N-1];
    assign mag      = operand[MAG_W-1:0];
    assign mag_zero = ~|mag;

    // Positives move to the upper half, and negatives have their magnitude
    // mirrored. Both zeros land on the single key that sits between them.
    always_comb begin
        if (mag_zero) begin
            key = {1'b1, {MAG_W{1'b0}}};
        end else begin
            key = {~sign_bit, mag ^ {MAG_W{sign_bit}}};
        end
    end
endmodule

// File: rtl/sm_ucmp.sv
module sm_ucmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         above,
    output logic         below
);
    // Scan from the MSB downward. The first differing bit decides.
    logic [W:0] above_run;
    logic [W:0] below_run;

    assign above_run[W] = 1'b0;
    assign below_run[W] = 1'b0;

    for (genvar i = W - 1; i >= 0; i--) begin : g_bit
        logic undecided;
        assign undecided    = ~(above_run[i+1] | below_run[i+1]);
        assign above_run[i] = above_run[i+1] | (undecided & lhs[i] & ~rhs[i]);
        assign below_run[i] = below_run[i+1] | (undecided & ~lhs[i] & rhs[i]);
    end

    assign above = above_run[0];
    assign below = below_run[0];
endmodule

// File: rtl/sm_order_cmp.sv
module sm_order_cmp
    import sm_cmp_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         raw_mode,
    output logic         gt,
    output logic         lt,
    output logic         eq
);
    logic [N-1:0] key_a;
    logic [N-1:0] key_b;
    logic [N-1:0] sel_a;
    logic [N-1:0] sel_b;
    logic         above;
    logic         below;
    cmp_mode_e    mode;
    order_flags_t flags;

    sm_key_map #(.N(N)) u_key_a (.operand(op_a), .key(key_a));
    sm_key_map #(.N(N)) u_key_b (.operand(op_b), .key(key_b));

    assign mode  = cmp_mode_e'(raw_mode);
    assign sel_a = (mode == CMP_RAW) ? op_a : key_a;
    assign sel_b = (mode == CMP_RAW) ? op_b : key_b;

    sm_ucmp #(.W(N)) u_ucmp (
        .lhs   (sel_a),
        .rhs   (sel_b),
        .above (above),
        .below (below)
    );

    assign flags = flags_from_run(above, below);
    assign gt    = flags.gt;
    assign lt    = flags.lt;
    assign eq    = flags.eq;
endmodule

// File: rtl/sm_order_cmp_chk.sv
module sm_order_cmp_chk #(
    parameter int N = 8
) (
    input logic [N-1:0] op_a,
    input logic [N-1:0] op_b,
    input logic         raw_mode,
    input logic         gt,
    input logic         lt,
    input logic         eq
);
    localparam int MAG_W = N - 1;

    logic a_zero;
    logic b_zero;
    assign a_zero = (op_a[MAG_W-1:0] == '0);
    assign b_zero = (op_b[MAG_W-1:0] == '0);

    always_comb begin
        // R7
        one_flag_chk: assert ($countones({gt, lt, eq}) == 1);
        // R5
        zero_pair_chk: assert (!(!raw_mode && a_zero && b_zero) || eq);
        // R2
        sign_split_chk: assert (!(!raw_mode && !a_zero && !b_zero && (op_a[N-1] != op_b[N-1]))
                                || (gt == !op_a[N-1]));
        // R8
        raw_order_chk: assert (!raw_mode || ((gt == (op_a > op_b)) && (lt == (op_a < op_b))));
        // R9
        raw_eq_chk: assert (!raw_mode || (eq == (op_a == op_b)));
    end
endmodule

bind sm_order_cmp sm_order_cmp_chk #(.N(N)) u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .raw_mode (raw_mode),
    .gt       (gt),
    .lt       (lt),
    .eq       (eq)
);

// File: tb/sm_order_cmp_tb.sv
module sm_order_cmp_tb;
    localparam int  N          = 5;
    localparam int  MAG_W      = N - 1;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    typedef struct {
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic         mode;
        logic         gt;
        logic         lt;
        logic         eq;
        string        tag;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] op_a = '0;
    logic [N-1:0] op_b = '0;
    logic         raw_mode = 1'b0;
    logic         gt, lt, eq;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    exp_item_t sb_q[$];

    sm_order_cmp #(.N(N)) u_dut (
        .op_a(op_a), .op_b(op_b), .raw_mode(raw_mode),
        .gt(gt), .lt(lt), .eq(eq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // R1: decode sign-magnitude into an integer
    function automatic int decode(input logic [N-1:0] v);
        int m;
        m = int'(v[MAG_W-1:0]);
        return v[N-1] ? -m : m;
    endfunction

    function automatic string pick_tag(input logic [N-1:0] a, input logic [N-1:0] b,
                                       input logic mode);
        bit za, zb;
        za = (a[MAG_W-1:0] == 0);
        zb = (b[MAG_W-1:0] == 0);
        if (mode)                 return "R8";
        if (za && zb)             return "R5";
        if (za || zb)             return "R6";
        if (a[N-1] != b[N-1])     return "R2";
        if (!a[N-1])              return "R3";
        return "R4";
    endfunction

    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input logic mode);
        exp_item_t it;
        int va, vb;
        @(posedge clk);
        op_a = a; op_b = b; raw_mode = mode;
        if (mode) begin
            va = int'(a); vb = int'(b);
        end else begin
            va = decode(a); vb = decode(b);
        end
        it.a = a; it.b = b; it.mode = mode;
        it.gt = (va > vb); it.lt = (va < vb); it.eq = (va == vb);
        it.tag = pick_tag(a, b, mode);
        sb_q.push_back(it);
    endtask

    // monitor: samples on the falling edge, after the driver's inputs settle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if ({gt, lt, eq} !== {it.gt, it.lt, it.eq}) begin
                n_fails++;
                $display("FAIL %s (R9 eq) a=%b b=%b raw=%0b got gt/lt/eq=%b%b%b exp=%b%b%b",
                         it.tag, it.a, it.b, it.mode, gt, lt, eq, it.gt, it.lt, it.eq);
            end
            n_checks++;
            if ($countones({gt, lt, eq}) != 1) begin
                n_fails++;
                $display("FAIL R7 a=%b b=%b got flags=%b%b%b exp=one-hot",
                         it.a, it.b, gt, lt, eq);
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // idle state: both inputs zero must read equal (R5)
        drive('0, '0, 1'b0);
        // named corners
        drive(5'b10000, 5'b00000, 1'b0); // R5: -0 vs +0
        drive(5'b10000, 5'b10001, 1'b0); // R6: -0 above -1
        drive(5'b00000, 5'b00001, 1'b0); // R6: +0 below +1
        drive(5'b10001, 5'b01111, 1'b0); // R2: -1 below +15
        drive(5'b10001, 5'b01111, 1'b1); // R8: raw pattern ranks above
        drive(5'b11111, 5'b10010, 1'b0); // R4: -15 below -2
        drive(5'b00011, 5'b01000, 1'b0); // R3
        // exhaustive sweep in both modes
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < (1 << N); a++)
                for (int b = 0; b < (1 << N); b++)
                    drive(N'(a), N'(b), m[0]);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule